// File: doc/BRIEF.md
# Machine-Cycle Status Latch and Bus Command Decoder

An 8-bit processor places a status byte on its data bus at the start of each machine cycle and pulses a sync line while the byte is valid. This block stores that byte. It then uses the stored bits to steer the processor's read strobe (active high) and write strobe (active low) onto one of five separate active-low commands: memory read, memory write, port read, port write and interrupt acknowledge. Memory and peripheral logic can then use these commands directly and do not have to decode addresses to tell the spaces apart.

The stored byte is also brought out unchanged, so that surrounding logic can see the full cycle type, including the stack-access and opcode-fetch flags. The command outputs are combinational from the stored byte and the strobes. A strobe therefore reaches its command in the same cycle it is driven, once the status for that machine cycle has been captured.

Top module: `cyc_status_decoder`

## Requirements
- R1: At a rising clock edge with `sync` high and reset released, `stat_q` takes the value on `dbus`. The new value is visible after that edge.
- R2: While `sync` is low, `stat_q` holds its value whatever `dbus` does.
- R3: While `rst_n` is low, `stat_q` is 0x00 and all five commands are high, whatever `sync`, `dbus` and the strobes do.
- R4: All commands are active low. With `rd_stb` low and `wr_n` high, every command is high.
- R5: Bit 0 (interrupt acknowledge) and bit 1 (read direction) both set, with `rd_stb` high, drive `inta_n` low and keep `mem_rd_n` high.
- R6: Bit 6 (input port) and bit 1 set, bit 0 clear, with `rd_stb` high, drive `io_rd_n` low.
- R7: Bit 7 (memory read) or bit 5 (opcode fetch) set, bit 1 set, bits 0 and 6 clear, with `rd_stb` high, drive `mem_rd_n` low.
- R8: Bit 4 (output port) set and bit 1 clear, with `wr_n` low, drive `io_wr_n` low.
- R9: Bit 1, bit 4 and bit 0 all clear, with `wr_n` low, drive `mem_wr_n` low.
- R10: While stored bit 3 (halt acknowledge) is set, every command is high.
- R11: A strobe that disagrees with stored bit 1 has no effect: `rd_stb` is ignored when bit 1 is clear, and `wr_n` is ignored when bit 1 is set.
- R12: At most one command is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbus | input | 8 | Processor data bus, carrying the status byte while `sync` is high |
| sync | input | 1 | Status-valid pulse, active high |
| rd_stb | input | 1 | Processor read strobe, active high |
| wr_n | input | 1 | Processor write strobe, active low |
| stat_q | output | 8 | Stored status byte |
| mem_rd_n | output | 1 | Memory read command, active low |
| mem_wr_n | output | 1 | Memory write command, active low |
| io_rd_n | output | 1 | Port read command, active low |
| io_wr_n | output | 1 | Port write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |

## Verification
The stored byte is due one clock edge after `sync` is sampled high. The commands have no register of their own, so they follow a strobe within the same cycle. The bench drives every input on the falling edge and samples two time units later, so each command is checked in the same half-cycle as its strobe and the status byte is checked after the single latching edge. The bench sweeps all 256 status bytes against all four strobe combinations. After each sweep step it clocks once more with `sync` low and a different bus value, to confirm that the stored byte has not moved.

// File: rtl/cycstat_pkg.sv
package cycstat_pkg;
  localparam int STW     = 8;
  // status bit positions, fixed by the processor's status byte
  localparam int B_INTA  = 0;
  localparam int B_RDIR  = 1;
  localparam int B_STACK = 2;
  localparam int B_HALT  = 3;
  localparam int B_OUT   = 4;
  localparam int B_FETCH = 5;
  localparam int B_IN    = 6;
  localparam int B_MEM   = 7;
  localparam int NCMD    = 5;

  typedef struct packed {
    logic mem_rd_n;
    logic mem_wr_n;
    logic io_rd_n;
    logic io_wr_n;
    logic inta_n;
  } cmd_t;

  localparam cmd_t CMD_IDLE = '{default: 1'b1};
endpackage

// File: rtl/status_capture.sv
module status_capture
  import cycstat_pkg::*;
#(
  parameter int W = STW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync,
  input  logic [W-1:0] dbus,
  output logic [W-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= '0;
    else if (sync) stat_q <= dbus;
  end

  assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (stat_q == $past(dbus)));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(stat_q));
endmodule

// File: rtl/cmd_route.sv
module cmd_route
  import cycstat_pkg::*;
#(
  parameter int W = STW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] stat,
  input  logic         rd_stb,
  input  logic         wr_n,
  output cmd_t         cmd
);
  logic halted, rd_ok, wr_ok;
  logic do_inta, do_iord, do_memrd, do_iowr, do_memwr;

  assign halted = stat[B_HALT];
  assign rd_ok  = rst_n && !halted && rd_stb && stat[B_RDIR];
  assign wr_ok  = rst_n && !halted && !wr_n && !stat[B_RDIR];

  // read side: interrupt acknowledge takes priority, then port, then memory
  assign do_inta  = rd_ok && stat[B_INTA];
  assign do_iord  = rd_ok && !stat[B_INTA] && stat[B_IN];
  assign do_memrd = rd_ok && !stat[B_INTA] && !stat[B_IN]
                    && (stat[B_MEM] || stat[B_FETCH]);
  // write side: port when the output flag is set, memory otherwise
  assign do_iowr  = wr_ok && stat[B_OUT];
  assign do_memwr = wr_ok && !stat[B_OUT] && !stat[B_INTA];

  always_comb begin
    cmd          = CMD_IDLE;
    cmd.inta_n   = !do_inta;
    cmd.io_rd_n  = !do_iord;
    cmd.mem_rd_n = !do_memrd;
    cmd.io_wr_n  = !do_iowr;
    cmd.mem_wr_n = !do_memwr;
  end

  assert_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cmd));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stat[B_HALT] |-> (&cmd));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && wr_n) |-> (&cmd));

  assert_reset_R3: assert property (@(posedge clk)
    !rst_n |-> (&cmd));
endmodule

// File: rtl/cyc_status_decoder.sv
module cyc_status_decoder
  import cycstat_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   dbus,
  input  logic         sync,
  input  logic         rd_stb,
  input  logic         wr_n,
  output logic [7:0]   stat_q,
  output logic         mem_rd_n,
  output logic         mem_wr_n,
  output logic         io_rd_n,
  output logic         io_wr_n,
  output logic         inta_n
);
  cmd_t cmd;

  status_capture #(.W(STW)) cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync   (sync),
    .dbus   (dbus),
    .stat_q (stat_q)
  );

  cmd_route #(.W(STW)) route_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat_q),
    .rd_stb (rd_stb),
    .wr_n   (wr_n),
    .cmd    (cmd)
  );

  assign mem_rd_n = cmd.mem_rd_n;
  assign mem_wr_n = cmd.mem_wr_n;
  assign io_rd_n  = cmd.io_rd_n;
  assign io_wr_n  = cmd.io_wr_n;
  assign inta_n   = cmd.inta_n;
endmodule

// File: tb/cyc_status_decoder_tb_top.sv
module cyc_status_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] dbus = 8'h00;
  logic       sync = 1'b0;
  logic       rd_stb = 1'b0;
  logic       wr_n = 1'b1;
  logic [7:0] stat_q;
  logic       mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_status_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .dbus(dbus), .sync(sync),
    .rd_stb(rd_stb), .wr_n(wr_n), .stat_q(stat_q),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n),
    .io_wr_n(io_wr_n), .inta_n(inta_n)
  );

  // order: {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n}
  function automatic logic [4:0] expect_cmds(input logic [7:0] s,
                                             input logic rd, input logic wn);
    logic [4:0] e;
    logic rdv, wrv;
    e   = 5'b11111;
    rdv = rd && s[1] && !s[3];
    wrv = !wn && !s[1] && !s[3];
    if (rdv && s[0])                          e[0] = 1'b0;
    if (rdv && !s[0] && s[6])                 e[2] = 1'b0;
    if (rdv && !s[0] && !s[6] && (s[7] || s[5])) e[4] = 1'b0;
    if (wrv && s[4])                          e[1] = 1'b0;
    if (wrv && !s[4] && !s[0])                e[3] = 1'b0;
    return e;
  endfunction

  function automatic string tag_for(input int idx, input logic [7:0] s,
                                    input logic rd, input logic wn);
    if (s[3]) return "R10";
    if (!rd && wn) return "R4";
    if ((idx == 0 || idx == 2 || idx == 4) && rd && !s[1]) return "R11";
    if ((idx == 1 || idx == 3) && !wn && s[1]) return "R11";
    case (idx)
      0: return "R5";
      1: return "R8";
      2: return "R6";
      3: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [4:0] cmds_now();
    return {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n};
  endfunction

  task automatic run_cycle(input logic [7:0] s, input logic rd, input logic wn,
                           input bit want_one);
    logic [4:0] e, a;
    @(negedge clk);
    dbus = s; sync = 1'b1; rd_stb = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    sync = 1'b0; dbus = ~s; rd_stb = rd; wr_n = wn;
    #2;
    check("R1", "status capture", stat_q, s);
    e = expect_cmds(s, rd, wn);
    a = cmds_now();
    for (int i = 0; i < 5; i++)
      check(tag_for(i, s, rd, wn), $sformatf("cmd bit %0d", i),
            {7'd0, a[i]}, {7'd0, e[i]});
    check("R12", "low command count", 8'($countones(~a)) > 8'd1 ? 8'd1 : 8'd0, 8'd0);
    if (want_one)
      check("R12", "exactly one command", 8'($countones(~a)), 8'd1);
    @(negedge clk);
    dbus = s ^ 8'h5A;
    #2;
    check("R2", "status hold", stat_q, s);
    rd_stb = 1'b0; wr_n = 1'b1;
  endtask

  initial begin
    // R3: reset state with busy inputs
    sync = 1'b1; dbus = 8'hFF; rd_stb = 1'b1; wr_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R3", "status in reset", stat_q, 8'h00);
    check("R3", "commands in reset", {3'd0, cmds_now()}, 8'h1F);
    @(negedge clk);
    sync = 1'b0; rd_stb = 1'b0; wr_n = 1'b1; rst_n = 1'b1;

    // named cycle types, each must assert exactly one command
    run_cycle(8'hA2, 1'b1, 1'b1, 1'b1); // opcode fetch
    run_cycle(8'h82, 1'b1, 1'b1, 1'b1); // memory read
    run_cycle(8'h86, 1'b1, 1'b1, 1'b1); // stack read
    run_cycle(8'h00, 1'b0, 1'b0, 1'b1); // memory write
    run_cycle(8'h04, 1'b0, 1'b0, 1'b1); // stack write
    run_cycle(8'h42, 1'b1, 1'b1, 1'b1); // port read
    run_cycle(8'h10, 1'b0, 1'b0, 1'b1); // port write
    run_cycle(8'h23, 1'b1, 1'b1, 1'b1); // interrupt acknowledge

    // exhaustive sweep
    for (int s = 0; s < 256; s++)
      for (int k = 0; k < 4; k++)
        run_cycle(8'(s), k[0], k[1], 1'b0);

    // R3: reset mid-activity forces commands high and clears status
    @(negedge clk);
    dbus = 8'h82; sync = 1'b1;
    @(negedge clk);
    sync = 1'b0; rd_stb = 1'b1; rst_n = 1'b0;
    #2;
    check("R3", "commands on reset assert", {3'd0, cmds_now()}, 8'h1F);
    check("R3", "status cleared by reset", stat_q, 8'h00);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule